// File: doc/BRIEF.md
# Stall and Clock-Loss Protection Supervisor

This block guards a three-phase motor drive against two failure modes while the motor is meant to turn: a rotor that never reaches speed lock, and a speed-command clock that has stopped. All timing is measured in ticks of a slow timebase strobe, so one set of parameters covers a wide range of system clocks. After power-up it also holds every gate off for a fixed initial interval before any drive is allowed.

Drive state means the start request is high, the brake request is low and the initial hold is over. In drive state an unlocked rotor advances a stall timer. When the timer reaches its set time, a stall fault is latched and the low-side gates are forced off. The fault stays latched until the start or brake input has been in its idle position for a minimum number of ticks and then returns to drive, or until the block is reset. A separate watchdog declares clock loss when no command-clock edge arrives within one thirty-fourth of the stall set time. Clock loss clears as soon as edges come back. Thermal and undervoltage faults arrive from outside and are mapped onto the gate commands. Any of clock loss, thermal fault or undervoltage freezes the stall timer.

Top module: `prot_supervisor`

## Requirements
- R1: After reset, `init_busy`, `all_gates_off` and `low_side_off` are high. `init_busy` falls after INIT_TICKS ticks. With no fault present, both gate-off outputs then fall.
- R2: In drive state with `lock_ok` low, `stall_fault` rises after STALL_TICKS consecutive ticks and is not set one tick earlier. While it is set, `low_side_off` is high and `all_gates_off` stays low.
- R3: A cycle with `lock_ok` high, or any cycle outside drive state, resets the stall timer to zero. A full STALL_TICKS of unlocked drive ticks is then needed again.
- R4: Once latched, `stall_fault` stays set when lock is regained. It also stays set when the start or brake input leaves drive for fewer than CLEAR_TICKS ticks and then returns.
- R5: `stall_fault` clears in the first drive-request cycle after the request has been idle for at least CLEAR_TICKS ticks. The idle period may come either from start low or from brake high.
- R6: In drive state, `clk_loss` rises after LOSS_TICKS = STALL_TICKS/34 ticks without a `cmd_edge`. Clock cycles without a tick do not count. While it is set, `low_side_off` is high.
- R7: A `cmd_edge` clears `clk_loss` in the cycle that follows.
- R8: While `clk_loss`, `thermal_flt` or `uv_flt` is active, the stall timer neither advances nor latches. If clock loss is declared in the same cycle the stall timer would expire, clock loss is raised and the stall fault is not.
- R9: `thermal_flt` raises `low_side_off` but not `all_gates_off`. `uv_flt` raises both outputs, in the same cycle as the input.
- R10: Outside drive state `clk_loss` is low, whether or not edges arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Timebase strobe; all timers count cycles where it is high |
| lock_ok | input | 1 | High when rotor speed is within the lock window |
| cmd_edge | input | 1 | One-cycle pulse per speed-command clock edge |
| start_req | input | 1 | High requests run, low requests stop |
| brake_req | input | 1 | High applies brake |
| thermal_flt | input | 1 | Thermal shutdown active |
| uv_flt | input | 1 | Supply undervoltage active |
| low_side_off | output | 1 | Force all low-side gates off |
| all_gates_off | output | 1 | Force every gate off |
| stall_fault | output | 1 | Latched stall fault |
| clk_loss | output | 1 | Command clock declared lost |
| init_busy | output | 1 | Initial power-on hold in progress |

## Verification
The critical overlap is the stall timer expiring on the same tick that the clock watchdog declares loss. The bench enters drive with an unlocked rotor and feeds edges often enough to keep the watchdog quiet. It then places the final edge exactly LOSS_TICKS ticks before the stall timer's last tick, so both thresholds land on the same clock edge. The check expects `clk_loss` set and `stall_fault` clear. It then resumes edges and expects the frozen stall timer to latch exactly one cycle after the clock-loss flag drops. A control run with unbroken edges shows that the stall fault does latch at that same cycle count.

// File: rtl/prot_sup_pkg.sv
package prot_sup_pkg;

  typedef struct packed {
    logic init_hold;
    logic uv;
    logic thermal;
    logic clk_loss;
    logic stall;
  } fault_t;

  // {all gates off, low side off}
  function automatic logic [1:0] gate_cmd(input fault_t f);
    logic all_off;
    logic low_off;
    all_off = f.init_hold | f.uv;
    low_off = all_off | f.thermal | f.clk_loss | f.stall;
    return {all_off, low_off};
  endfunction

endpackage

// File: rtl/prot_tick_timer.sv
module prot_tick_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic done,
  output logic hit
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          step;

  assign step = run && tick && !done;
  assign hit  = !clear && step && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/prot_gate_map.sv
module prot_gate_map
  import prot_sup_pkg::*;
(
  input  fault_t flt,
  output logic   low_off,
  output logic   all_off
);
  logic [1:0] cmd;
  assign cmd     = gate_cmd(flt);
  assign all_off = cmd[1];
  assign low_off = cmd[0];
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_sup_pkg::*;
#(
  parameter int unsigned STALL_TICKS = 3400,
  parameter int unsigned LOSS_DIV    = 34,
  parameter int unsigned CLEAR_TICKS = 1000,
  parameter int unsigned INIT_TICKS  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lock_ok,
  input  logic cmd_edge,
  input  logic start_req,
  input  logic brake_req,
  input  logic thermal_flt,
  input  logic uv_flt,
  output logic low_side_off,
  output logic all_gates_off,
  output logic stall_fault,
  output logic clk_loss,
  output logic init_busy
);
  localparam int unsigned LOSS_TICKS = (STALL_TICKS / LOSS_DIV > 0) ? STALL_TICKS / LOSS_DIV : 1;

  logic init_done, init_hit;
  logic drive_req, drive;
  logic loss_hit;
  logic inhibit;
  logic stall_clear, stall_hit;
  logic idle_done, idle_hit;
  logic clr_pulse;
  logic unused_hits;
  fault_t flt;

  // Power-on hold
  prot_tick_timer #(.LIMIT(INIT_TICKS)) u_init (
    .clk(clk), .rst_n(rst_n), .clear(1'b0), .run(1'b1), .tick(tick),
    .done(init_done), .hit(init_hit)
  );
  assign init_busy = !init_done;

  assign drive_req = start_req && !brake_req;
  assign drive     = drive_req && init_done;

  // Command clock watchdog
  prot_tick_timer #(.LIMIT(LOSS_TICKS)) u_loss (
    .clk(clk), .rst_n(rst_n), .clear(cmd_edge || !drive), .run(1'b1), .tick(tick),
    .done(clk_loss), .hit(loss_hit)
  );

  // Idle-duration detector for fault release
  prot_tick_timer #(.LIMIT(CLEAR_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .clear(drive_req), .run(1'b1), .tick(tick),
    .done(idle_done), .hit(idle_hit)
  );
  assign clr_pulse = drive_req && idle_done;

  // Stall timer: sticky once expired, released only by clr_pulse
  assign inhibit     = clk_loss || loss_hit || thermal_flt || uv_flt;
  assign stall_clear = clr_pulse || (!stall_fault && (lock_ok || !drive));

  prot_tick_timer #(.LIMIT(STALL_TICKS)) u_stall (
    .clk(clk), .rst_n(rst_n), .clear(stall_clear), .run(!inhibit), .tick(tick),
    .done(stall_fault), .hit(stall_hit)
  );

  assign unused_hits = init_hit ^ stall_hit ^ idle_hit;

  assign flt.init_hold = init_busy;
  assign flt.uv        = uv_flt;
  assign flt.thermal   = thermal_flt;
  assign flt.clk_loss  = clk_loss;
  assign flt.stall     = stall_fault;

  prot_gate_map u_map (
    .flt(flt), .low_off(low_side_off), .all_off(all_gates_off)
  );
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_edge,
  input logic thermal_flt,
  input logic uv_flt,
  input logic low_side_off,
  input logic all_gates_off,
  input logic stall_fault,
  input logic clk_loss,
  input logic init_busy,
  input logic drive,
  input logic clr_pulse
);
  AST_INIT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> all_gates_off); // R1
  AST_STALL_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fault |-> low_side_off); // R2
  AST_STALL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fault && !clr_pulse |=> stall_fault); // R4
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !stall_fault); // R5
  AST_LOSS_IN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_loss) |-> $past(drive)); // R10
  AST_EDGE_ENDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_edge |=> !clk_loss); // R7
  AST_NO_STALL_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_fault) |-> !$past(clk_loss) && !$past(thermal_flt) && !$past(uv_flt)); // R8
  AST_ALL_IMPLIES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    all_gates_off |-> low_side_off); // R9
  AST_LOSS_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clk_loss |-> low_side_off); // R6
endmodule

bind prot_supervisor prot_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_edge(cmd_edge), .thermal_flt(thermal_flt),
  .uv_flt(uv_flt), .low_side_off(low_side_off), .all_gates_off(all_gates_off),
  .stall_fault(stall_fault), .clk_loss(clk_loss), .init_busy(init_busy),
  .drive(drive), .clr_pulse(clr_pulse)
);

// File: tb/test_prot_supervisor.sv
`timescale 1ns/1ps
module test_prot_supervisor;
  localparam int STALL = 340;
  localparam int LOSS  = STALL / 34;
  localparam int CLR   = 20;
  localparam int INIT  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic lock_ok = 1'b0;
  logic cmd_edge = 1'b0;
  logic start_req = 1'b0;
  logic brake_req = 1'b1;
  logic thermal_flt = 1'b0;
  logic uv_flt = 1'b0;
  logic low_side_off, all_gates_off, stall_fault, clk_loss, init_busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prot_supervisor #(.STALL_TICKS(STALL), .LOSS_DIV(34), .CLEAR_TICKS(CLR), .INIT_TICKS(INIT))
  i_prot_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lock_ok(lock_ok), .cmd_edge(cmd_edge),
    .start_req(start_req), .brake_req(brake_req), .thermal_flt(thermal_flt), .uv_flt(uv_flt),
    .low_side_off(low_side_off), .all_gates_off(all_gates_off), .stall_fault(stall_fault),
    .clk_loss(clk_loss), .init_busy(init_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // iteration i drives the i-th following rising edge
  task automatic run_cycles(input int n, input int edge_period);
    for (int i = 0; i < n; i++) begin
      cmd_edge = (edge_period > 0) && (i % edge_period == 0);
      @(negedge clk);
    end
    cmd_edge = 1'b0;
  endtask

  task automatic release_fault();
    start_req = 1'b0;
    run_cycles(CLR, 0);
    start_req = 1'b1;
    lock_ok = 1'b1;
    run_cycles(1, 0);
  endtask

  task automatic t_init();
    check("R1 init_busy after reset", init_busy, 1);
    check("R1 all_gates_off after reset", all_gates_off, 1);
    check("R1 low_side_off after reset", low_side_off, 1);
    run_cycles(INIT - 1, 0);
    check("R1 still busy one tick early", init_busy, 1);
    run_cycles(1, 0);
    check("R1 busy ends", init_busy, 0);
    check("R1 all off released", all_gates_off, 0);
    check("R1 low off released", low_side_off, 0);
  endtask

  task automatic t_stall();
    lock_ok = 1'b0; start_req = 1'b1; brake_req = 1'b0;
    run_cycles(STALL - 1, 5);
    check("R2 no stall one tick early", stall_fault, 0);
    run_cycles(1, 5);
    check("R2 stall latched", stall_fault, 1);
    check("R2 low side off on stall", low_side_off, 1);
    check("R2 all off stays low", all_gates_off, 0);
  endtask

  task automatic t_short_release();
    start_req = 1'b0;
    run_cycles(CLR - 1, 0);
    start_req = 1'b1;
    lock_ok = 1'b1;
    run_cycles(1, 0);
    check("R4 short stop keeps stall", stall_fault, 1);
    run_cycles(5, 0);
    check("R4 lock keeps stall", stall_fault, 1);
  endtask

  task automatic t_release();
    release_fault();
    check("R5 release by start", stall_fault, 0);
    lock_ok = 1'b0;
    run_cycles(STALL, 5);
    check("R2 stall latched again", stall_fault, 1);
    brake_req = 1'b1;
    run_cycles(CLR, 0);
    brake_req = 1'b0;
    lock_ok = 1'b1;
    run_cycles(1, 0);
    check("R5 release by brake", stall_fault, 0);
  endtask

  task automatic t_lock_restart();
    lock_ok = 1'b0;
    run_cycles(300, 5);
    lock_ok = 1'b1;
    run_cycles(1, 1);
    lock_ok = 1'b0;
    run_cycles(STALL - 1, 5);
    check("R3 lock restarted timer", stall_fault, 0);
    run_cycles(1, 5);
    check("R3 full time after lock", stall_fault, 1);
    release_fault();
    check("R5 release after R3", stall_fault, 0);
  endtask

  task automatic t_clock_loss();
    lock_ok = 1'b1;
    run_cycles(1, 1);
    tick = 1'b0;
    run_cycles(30, 0);
    check("R6 no count without tick", clk_loss, 0);
    tick = 1'b1;
    run_cycles(LOSS - 1, 0);
    check("R6 no loss one tick early", clk_loss, 0);
    run_cycles(1, 0);
    check("R6 loss declared", clk_loss, 1);
    check("R6 low side off on loss", low_side_off, 1);
    run_cycles(1, 1);
    check("R7 edge clears loss", clk_loss, 0);
    start_req = 1'b0;
    run_cycles(30, 0);
    check("R10 no loss outside drive", clk_loss, 0);
    start_req = 1'b1;
    run_cycles(1, 1);
  endtask

  task automatic t_thermal_hold();
    lock_ok = 1'b0;
    run_cycles(200, 5);
    thermal_flt = 1'b1;
    #1;
    check("R9 thermal low side off", low_side_off, 1);
    check("R9 thermal not all off", all_gates_off, 0);
    run_cycles(300, 5);
    check("R8 thermal holds stall timer", stall_fault, 0);
    thermal_flt = 1'b0;
    run_cycles(STALL - 200 - 1, 5);
    check("R8 timer resumed not expired", stall_fault, 0);
    run_cycles(1, 5);
    check("R8 timer resumed expires", stall_fault, 1);
    release_fault();
  endtask

  task automatic t_coincide();
    lock_ok = 1'b0;
    for (int k = 0; k < STALL; k++) begin
      cmd_edge = (k == STALL - 1 - LOSS) || ((k % 5 == 0) && (k < STALL - 1 - LOSS));
      @(negedge clk);
    end
    cmd_edge = 1'b0;
    check("R8 coincident loss wins", clk_loss, 1);
    check("R8 coincident no stall", stall_fault, 0);
    run_cycles(20, 0);
    check("R8 loss holds stall timer", stall_fault, 0);
    run_cycles(1, 1);
    check("R7 loss cleared by edge", clk_loss, 0);
    check("R8 held one more cycle", stall_fault, 0);
    run_cycles(1, 0);
    check("R8 stall latches after loss", stall_fault, 1);
    release_fault();
  endtask

  task automatic t_uv();
    uv_flt = 1'b1;
    #1;
    check("R9 uv all off", all_gates_off, 1);
    check("R9 uv low off", low_side_off, 1);
    lock_ok = 1'b0;
    run_cycles(STALL + 60, 5);
    check("R8 uv holds stall timer", stall_fault, 0);
    uv_flt = 1'b0;
    lock_ok = 1'b1;
    run_cycles(1, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_init();
    t_stall();
    t_short_release();
    t_release();
    t_lock_restart();
    t_clock_loss();
    t_thermal_hold();
    t_coincide();
    t_uv();
    finish_run();
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule